// File: doc/BRIEF.md
# Banked GPIO Register File

This block is the software-visible register file of a general-purpose I/O controller with up to 128 pins, split into four banks of 32 pins. A single-cycle bus reads and writes a 512-byte offset window. Behind it sit the per-bank direction, output latch, edge-detect enables and alternate-function words. Pin n lives in bank n/32 at bit n mod 32.

Outputs never change through a plain write of the latch. Software raises latch bits through a set register and lowers them through a clear register. The driven value of a pin is the latch bit gated by its direction bit. The pin-level register returns, per pin, either the latch bit (output pins) or the sampled input (input pins).

The edge-detection logic sits outside this block. It supplies its status vector for read-back and receives a write-one-to-clear mask during a status write. Bank 3 sits in a separate high window of the map.

Top module: `gpio_bank_regfile`

## Requirements
- R1: Pin n is controlled by bank n/32 at bit n mod 32 of that bank's registers; flat pin vectors place bank b at bits [32b+31:32b].
- R2: After a synchronous active-low reset all stored registers are zero: `pin_dir`, `pin_out`, `rise_en`, `fall_en` are 0, as are `bus_rdata`, `bus_err` and `level_rd_pulse`.
- R3: Direction words sit at 0x00C, 0x010, 0x014 and 0x10C for banks 0 to 3. Rising-enable words sit at 0x030, 0x034, 0x038 and 0x130. Falling-enable words sit at 0x03C, 0x040, 0x044 and 0x13C. All three are read/write, and they drive `pin_dir`, `rise_en` and `fall_en`.
- R4: A write to a set offset (0x018, 0x01C, 0x020, 0x118) ORs the data into that bank's output latch. A read there returns the last value written to it.
- R5: A write to a clear offset (0x024, 0x028, 0x02C, 0x124) clears latch bits where the data has ones. A read there returns the constant 0x00007A69.
- R6: A read of a pin-level offset (0x000, 0x004, 0x008, 0x100) returns the latch bit where the direction bit is 1, and the `pin_in` bit where it is 0.
- R7: `pin_out` equals the output latch ANDed with the direction bits. An input pin drives 0, and its latch bit is kept for later.
- R8: A read of an edge-status offset (0x048, 0x04C, 0x050, 0x148) returns that bank's slice of `edge_status`. During a write there, `edge_clr` carries the written data in that bank's slice, and it is zero elsewhere and at all other times.
- R9: The alternate-function low words (0x054, 0x05C, 0x064, 0x06C) and high words (0x058, 0x060, 0x068, 0x070) for banks 0 to 3 are plain read/write storage.
- R10: Accesses at offsets 0x200 and above read 0 and do not flag an error. Writes there change nothing, even where the low nine address bits alias a mapped register.
- R11: An access below 0x200 that hits no register, including a misaligned one, reads 0 and leaves all state unchanged. It raises `bus_err` for exactly one cycle.
- R12: `level_rd_pulse` is high for one cycle after each pin-level read, and only then.
- R13: Writes to pin-level offsets are ignored without an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_err | output | 1 | Unmapped-offset flag, registered |
| level_rd_pulse | output | 1 | Pin-level read notification |
| pin_in | input | 128 | Sampled input levels |
| pin_out | output | 128 | Effective driven output per pin |
| pin_dir | output | 128 | Direction, 1 = output |
| rise_en | output | 128 | Rising-edge detect enables |
| fall_en | output | 128 | Falling-edge detect enables |
| edge_status | input | 128 | Edge status from the edge unit |
| edge_clr | output | 128 | Clear mask to the edge unit |

## Verification
`bus_rdata`, `bus_err` and `level_rd_pulse` are registered. They describe the access presented in the previous cycle, so the bench drives an access at a falling edge and samples these outputs at the next falling edge. `edge_clr` is combinational from the bus and is sampled shortly after the write is driven, before the capturing edge. Register writes take effect at the capturing edge, so `pin_out`, `pin_dir`, `rise_en` and `fall_en` are checked at the falling edge that follows the write. Each check is also made with a read-back one access later.

// File: rtl/gpio_rf_pkg.sv
// Shared types for the banked GPIO register file.
package gpio_rf_pkg;

    // Register kind selected by an offset; K_NONE means no register.
    typedef enum logic [3:0] {
        K_NONE,
        K_LEVEL,
        K_DIR,
        K_SET,
        K_CLR,
        K_RISE,
        K_FALL,
        K_STAT,
        K_ALT_LO,
        K_ALT_HI
    } reg_kind_e;

    // Kind of the n-th 12-byte register group in the low window.
    function automatic reg_kind_e kind_of_group(input int g);
        case (g)
            0: return K_LEVEL;
            1: return K_DIR;
            2: return K_SET;
            3: return K_CLR;
            4: return K_RISE;
            5: return K_FALL;
            6: return K_STAT;
            default: return K_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
// Offset decoder. Maps a byte offset to a register kind and a bank index.
// Assumes four banks. The low window holds seven groups of three words
// (banks 0..2) followed by eight alternate-function words. Bank 3 repeats
// the group layout from offset 0x100 with one word per group.
module gpio_addr_decode
    import gpio_rf_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int SPAN_BYTES = 512,
    parameter int BANK_IDX_W = 2,
    parameter int HI_BASE    = 'h100,
    parameter int ALT_BASE   = 'h054,
    parameter int ALT_WORDS  = 8
) (
    input  logic [ADDR_W-1:0]     addr,
    output reg_kind_e             kind,
    output logic [BANK_IDX_W-1:0] bank,
    output logic                  in_span
);
    localparam int GROUPS    = 7;
    localparam int GROUP_B   = 12;
    localparam int LOW_END   = GROUPS * GROUP_B;
    localparam int HI_END    = HI_BASE + LOW_END;
    localparam int ALT_END   = ALT_BASE + 4 * ALT_WORDS;
    localparam int HI_BANK   = 3;

    int off;
    int rel;

    // Classify the offset into kind and bank.
    always_comb begin
        kind    = K_NONE;
        bank    = '0;
        in_span = (int'(addr) < SPAN_BYTES);
        off     = int'(addr);
        rel     = 0;
        if (in_span && (addr[1:0] == 2'b00)) begin
            if (off < LOW_END) begin
                kind = kind_of_group(off / GROUP_B);
                bank = BANK_IDX_W'((off % GROUP_B) / 4);
            end else if (off >= ALT_BASE && off < ALT_END) begin
                rel  = (off - ALT_BASE) / 4;
                kind = (rel % 2 == 1) ? K_ALT_HI : K_ALT_LO;
                bank = BANK_IDX_W'(rel / 2);
            end else if (off >= HI_BASE && off < HI_END) begin
                rel = off - HI_BASE;
                if (rel % GROUP_B == 0) begin
                    kind = kind_of_group(rel / GROUP_B);
                    bank = BANK_IDX_W'(HI_BANK);
                end
            end
        end
    end

endmodule

// File: rtl/gpio_bank_slice.sv
// Storage for one 32-pin bank: direction, output latch, last set value,
// edge enables and the two alternate-function words.
// Assumes wr_en is asserted only for this bank and a mapped kind.
module gpio_bank_slice
    import gpio_rf_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  reg_kind_e    kind,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] dir,
    output logic [W-1:0] olat,
    output logic [W-1:0] set_last,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall,
    output logic [W-1:0] alt_lo,
    output logic [W-1:0] alt_hi
);
    // Update the addressed register of this bank on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir      <= '0;
            olat     <= '0;
            set_last <= '0;
            rise     <= '0;
            fall     <= '0;
            alt_lo   <= '0;
            alt_hi   <= '0;
        end else if (wr_en) begin
            case (kind)
                K_DIR:    dir    <= wdata;
                K_SET: begin
                    olat     <= olat | wdata;
                    set_last <= wdata;
                end
                K_CLR:    olat   <= olat & ~wdata;
                K_RISE:   rise   <= wdata;
                K_FALL:   fall   <= wdata;
                K_ALT_LO: alt_lo <= wdata;
                K_ALT_HI: alt_hi <= wdata;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_read_mux.sv
// Read-data selector. Picks the word for a kind and bank. Pin-level
// words merge the latch and the input per direction bit. Returns 0 for
// K_NONE.
module gpio_read_mux
    import gpio_rf_pkg::*;
#(
    parameter int          W          = 32,
    parameter int          NB         = 4,
    parameter int          BANK_IDX_W = 2,
    parameter logic [31:0] CLR_VALUE  = 32'h0000_7A69
) (
    input  reg_kind_e               kind,
    input  logic [BANK_IDX_W-1:0]   bank,
    input  logic [NB-1:0][W-1:0]    dir,
    input  logic [NB-1:0][W-1:0]    olat,
    input  logic [NB-1:0][W-1:0]    set_last,
    input  logic [NB-1:0][W-1:0]    rise,
    input  logic [NB-1:0][W-1:0]    fall,
    input  logic [NB-1:0][W-1:0]    alt_lo,
    input  logic [NB-1:0][W-1:0]    alt_hi,
    input  logic [NB-1:0][W-1:0]    lvl_in,
    input  logic [NB-1:0][W-1:0]    stat,
    output logic [W-1:0]            rword
);
    // Select the read word.
    always_comb begin
        case (kind)
            K_LEVEL:  rword = (olat[bank] & dir[bank]) | (lvl_in[bank] & ~dir[bank]);
            K_DIR:    rword = dir[bank];
            K_SET:    rword = set_last[bank];
            K_CLR:    rword = W'(CLR_VALUE);
            K_RISE:   rword = rise[bank];
            K_FALL:   rword = fall[bank];
            K_STAT:   rword = stat[bank];
            K_ALT_LO: rword = alt_lo[bank];
            K_ALT_HI: rword = alt_hi[bank];
            default:  rword = '0;
        endcase
    end

endmodule

// File: rtl/gpio_bank_regfile.sv
// Banked GPIO register file (top). Bus reads return registered data one
// cycle after the access. Writes take effect at the access edge. The edge
// clear mask is combinational during a status write. Assumes one access
// per cycle and a fixed four-bank map.
module gpio_bank_regfile
    import gpio_rf_pkg::*;
#(
    parameter int          NUM_BANKS  = 4,
    parameter int          BANK_W     = 32,
    parameter int          ADDR_W     = 12,
    parameter int          SPAN_BYTES = 512,
    parameter logic [31:0] CLR_VALUE  = 32'h0000_7A69
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_sel,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [BANK_W-1:0]           bus_wdata,
    output logic [BANK_W-1:0]           bus_rdata,
    output logic                        bus_err,
    output logic                        level_rd_pulse,
    input  logic [NUM_BANKS*BANK_W-1:0] pin_in,
    output logic [NUM_BANKS*BANK_W-1:0] pin_out,
    output logic [NUM_BANKS*BANK_W-1:0] pin_dir,
    output logic [NUM_BANKS*BANK_W-1:0] rise_en,
    output logic [NUM_BANKS*BANK_W-1:0] fall_en,
    input  logic [NUM_BANKS*BANK_W-1:0] edge_status,
    output logic [NUM_BANKS*BANK_W-1:0] edge_clr
);
    localparam int BANK_IDX_W = $clog2(NUM_BANKS);

    reg_kind_e                      kind;
    logic [BANK_IDX_W-1:0]          bank;
    logic                           in_span;
    logic                           wr_acc;
    logic                           rd_acc;
    logic [NUM_BANKS-1:0][BANK_W-1:0] dir_b, olat_b, set_b, rise_b, fall_b;
    logic [NUM_BANKS-1:0][BANK_W-1:0] altl_b, alth_b, in_b, stat_b, clr_b;
    logic [BANK_W-1:0]              rword;

    gpio_addr_decode #(
        .ADDR_W     (ADDR_W),
        .SPAN_BYTES (SPAN_BYTES),
        .BANK_IDX_W (BANK_IDX_W)
    ) u_dec (
        .addr    (bus_addr),
        .kind    (kind),
        .bank    (bank),
        .in_span (in_span)
    );

    assign wr_acc = bus_sel && bus_wr;
    assign rd_acc = bus_sel && !bus_wr;
    assign in_b   = pin_in;
    assign stat_b = edge_status;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic bank_wr;
        assign bank_wr = wr_acc && (kind != K_NONE) && (bank == BANK_IDX_W'(b));

        gpio_bank_slice #(.W(BANK_W)) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (bank_wr),
            .kind     (kind),
            .wdata    (bus_wdata),
            .dir      (dir_b[b]),
            .olat     (olat_b[b]),
            .set_last (set_b[b]),
            .rise     (rise_b[b]),
            .fall     (fall_b[b]),
            .alt_lo   (altl_b[b]),
            .alt_hi   (alth_b[b])
        );

        // Edge-unit clear mask for this bank during a status write.
        assign clr_b[b]  = (bank_wr && kind == K_STAT) ? bus_wdata : '0;
        // Effective driven output of this bank.
        assign pin_out[b*BANK_W +: BANK_W] = olat_b[b] & dir_b[b];
    end

    assign pin_dir  = dir_b;
    assign rise_en  = rise_b;
    assign fall_en  = fall_b;
    assign edge_clr = clr_b;

    gpio_read_mux #(
        .W          (BANK_W),
        .NB         (NUM_BANKS),
        .BANK_IDX_W (BANK_IDX_W),
        .CLR_VALUE  (CLR_VALUE)
    ) u_rmux (
        .kind     (kind),
        .bank     (bank),
        .dir      (dir_b),
        .olat     (olat_b),
        .set_last (set_b),
        .rise     (rise_b),
        .fall     (fall_b),
        .alt_lo   (altl_b),
        .alt_hi   (alth_b),
        .lvl_in   (in_b),
        .stat     (stat_b),
        .rword    (rword)
    );

    // Register read data, the unmapped flag and the level-read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata      <= '0;
            bus_err        <= 1'b0;
            level_rd_pulse <= 1'b0;
        end else begin
            bus_rdata      <= rd_acc ? rword : '0;
            bus_err        <= bus_sel && in_span && (kind == K_NONE);
            level_rd_pulse <= rd_acc && (kind == K_LEVEL);
        end
    end

endmodule

// File: rtl/gpio_rf_checker.sv
// Property checker for gpio_bank_regfile, attached by bind below.
module gpio_rf_checker #(
    parameter int NB = 4,
    parameter int W  = 32,
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [W-1:0]  bus_wdata,
    input logic [W-1:0]  bus_rdata,
    input logic          bus_err,
    input logic          level_rd_pulse,
    input logic [NB*W-1:0] pin_in,
    input logic [NB*W-1:0] pin_out,
    input logic [NB*W-1:0] pin_dir,
    input logic [NB*W-1:0] rise_en,
    input logic [NB*W-1:0] fall_en,
    input logic [NB*W-1:0] edge_status,
    input logic [NB*W-1:0] edge_clr
);
    // Reset clears the driven outputs and the bus flags.
    assert_reset_clear_R2: assert property (@(posedge clk)
        !rst_n |=> (pin_out == '0 && pin_dir == '0 && !bus_err && !level_rd_pulse));

    // Input pins never drive high.
    assert_input_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_dir) == '0);

    // Set write raises every written bit on output pins of bank 0.
    assert_set_raises_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == AW'('h018))
        |=> (($past(bus_wdata) & pin_dir[W-1:0] & ~pin_out[W-1:0]) == '0));

    // Clear write lowers every written bit of bank 0.
    assert_clear_lowers_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == AW'('h024))
        |=> ((pin_out[W-1:0] & $past(bus_wdata)) == '0));

    // Clear mask only appears during a write.
    assert_clr_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr) |-> (edge_clr == '0));

    // Out-of-span reads return zero without error.
    assert_oor_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr >= AW'('h200)) |=> (bus_rdata == '0 && !bus_err));

    // No error without an access in the previous cycle.
    assert_err_needs_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> !bus_err);

    // Level strobe only follows a read.
    assert_pulse_needs_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> !level_rd_pulse);

endmodule

bind gpio_bank_regfile gpio_rf_checker u_chk (.*);

// File: tb/gpio_bank_regfile_bench.sv
// Directed bench for gpio_bank_regfile.
module gpio_bank_regfile_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0;
    logic         bus_wr = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         bus_err;
    logic         level_rd_pulse;
    logic [127:0] pin_in = '0;
    logic [127:0] pin_out, pin_dir, rise_en, fall_en;
    logic [127:0] edge_status = '0;
    logic [127:0] edge_clr;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    logic [31:0] r_data;
    logic        r_err;
    logic        r_pulse;

    gpio_bank_regfile u_gpio_bank_regfile (.*);

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        r_err = bus_err;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [11:0] a);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        r_data = bus_rdata; r_err = bus_err; r_pulse = level_rd_pulse;
        bus_sel = 0;
    endtask

    task automatic t_reset;
        chk("R2 pin_out", pin_out, '0);
        chk("R2 pin_dir", pin_dir, '0);
        chk("R2 enables", rise_en | fall_en, '0);
        chk("R2 flags", {bus_rdata, bus_err, level_rd_pulse}, '0);
        bus_read(12'h10C);
        chk("R2 dir3 read", r_data, '0);
    endtask

    task automatic t_dirmap;
        bus_write(12'h00C, 32'h1111_0001);
        bus_write(12'h010, 32'h2222_0002);
        bus_write(12'h014, 32'h3333_0003);
        bus_write(12'h10C, 32'h4444_0004);
        chk("R1 pin_dir banks", pin_dir, {32'h4444_0004, 32'h3333_0003, 32'h2222_0002, 32'h1111_0001});
        bus_read(12'h014);
        chk("R3 dir2 readback", r_data, 32'h3333_0003);
        bus_read(12'h10C);
        chk("R3 dir3 readback", r_data, 32'h4444_0004);
        bus_write(12'h030, 32'hA5A5_A5A5);
        bus_write(12'h13C, 32'h5A5A_0000);
        bus_read(12'h030);
        chk("R3 rise0 readback", r_data, 32'hA5A5_A5A5);
        chk("R3 rise_en", rise_en, {96'h0, 32'hA5A5_A5A5});
        chk("R3 fall_en", fall_en, {32'h5A5A_0000, 96'h0});
        bus_read(12'h13C);
        chk("R3 fall3 readback", r_data, 32'h5A5A_0000);
    endtask

    task automatic t_set_clear;
        bus_write(12'h010, 32'hFFFF_0000);
        bus_write(12'h01C, 32'h00FF_FF00);
        chk("R7 bank1 out gated", pin_out[63:32], 32'h00FF_0000);
        bus_read(12'h01C);
        chk("R4 set readback", r_data, 32'h00FF_FF00);
        bus_write(12'h01C, 32'h0000_0001);
        bus_read(12'h01C);
        chk("R4 set last value", r_data, 32'h0000_0001);
        bus_write(12'h028, 32'h00F0_0000);
        chk("R5 cleared", pin_out[63:32], 32'h000F_0000);
        bus_read(12'h028);
        chk("R5 clear read const", r_data, 32'h0000_7A69);
        bus_write(12'h010, 32'hFFFF_FFFF);
        chk("R4 R7 latch kept", pin_out[63:32], 32'h000F_FF01);
        chk("R1 other banks idle", {pin_out[127:64], pin_out[31:0]}, '0);
    endtask

    task automatic t_level;
        bus_write(12'h10C, 32'h0000_FFFF);
        bus_write(12'h118, 32'h1234_5678);
        pin_in[127:96] = 32'hCAFE_BEEF;
        bus_read(12'h100);
        chk("R6 level merge", r_data, 32'hCAFE_5678);
        chk("R12 pulse on level read", r_pulse, 1'b1);
        @(negedge clk);
        chk("R12 pulse one cycle", level_rd_pulse, 1'b0);
        bus_read(12'h10C);
        chk("R12 no pulse on other read", r_pulse, 1'b0);
        bus_write(12'h100, 32'hFFFF_FFFF);
        chk("R13 level write no error", r_err, 1'b0);
        bus_read(12'h100);
        chk("R13 level write ignored", r_data, 32'hCAFE_5678);
        chk("R13 out unchanged", pin_out[127:96], 32'h0000_5678);
    endtask

    task automatic t_edge;
        edge_status[95:64] = 32'h8000_0001;
        bus_read(12'h050);
        chk("R8 status read", r_data, 32'h8000_0001);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 12'h04C; bus_wdata = 32'h0F0F_0000;
        #1;
        chk("R8 clear mask", edge_clr, {64'h0, 32'h0F0F_0000, 32'h0});
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
        #1;
        chk("R8 mask idle", edge_clr, '0);
    endtask

    task automatic t_alt;
        for (int i = 0; i < 8; i++)
            bus_write(12'h054 + 12'(4 * i), 32'hA17_0000 + 32'(i));
        for (int i = 0; i < 8; i++) begin
            bus_read(12'h054 + 12'(4 * i));
            chk("R9 alt readback", r_data, 32'hA17_0000 + 32'(i));
        end
    endtask

    task automatic t_out_of_range;
        bus_write(12'h20C, 32'hDEAD_BEEF);
        chk("R10 oor write no error", r_err, 1'b0);
        bus_read(12'h00C);
        chk("R10 alias untouched", r_data, 32'h1111_0001);
        bus_read(12'h20C);
        chk("R10 oor read zero", {r_data, r_err}, '0);
        bus_read(12'hFFC);
        chk("R10 top read zero", {r_data, r_err}, '0);
    endtask

    task automatic t_unmapped;
        bus_read(12'h074);
        chk("R11 read error", {r_data, r_err}, {32'h0, 1'b1});
        @(negedge clk);
        chk("R11 error one cycle", bus_err, 1'b0);
        bus_write(12'h104, 32'hFFFF_FFFF);
        chk("R11 hole write error", r_err, 1'b1);
        bus_read(12'h010);
        chk("R11 dir1 unchanged", r_data, 32'hFFFF_FFFF);
        bus_write(12'h00E, 32'h0);
        chk("R11 misaligned error", r_err, 1'b1);
        bus_read(12'h00C);
        chk("R11 dir0 unchanged", r_data, 32'h1111_0001);
        bus_read(12'h0F0);
        chk("R11 gap read", {r_data, r_err}, {32'h0, 1'b1});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_dirmap();
        t_set_clear();
        t_level();
        t_edge();
        t_alt();
        t_out_of_range();
        t_unmapped();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule